// File: doc/BRIEF.md
# DMA Interrupt Aggregator

This block collects interrupt requests from a parameterised number of DMA pipes and from four global controller events, and turns them into one interrupt line per execution environment. Each global event is a single-cycle pulse. The pulse sets a sticky status bit. Software enables status bits through an enable register and clears them through a write-one-to-clear register.

The enabled global status is reduced to a single summary bit. That bit sits at bit 31 of a sources word. The low bits of the same word carry the level of each pipe's interrupt request. The sources word is visible before masking. Each execution environment also has its own mask register and sees a masked copy of the word. An environment's interrupt line is registered and rises when any bit of its masked word is set.

The register bus decoder sits outside this block. It presents each write as a strobe with write data. Every readable register is presented as a plain output.

Top module: `irqagg_top`

## Requirements
- R1: After reset, global status, global enable and every environment mask read zero, and every interrupt line is low.
- R2: A pulse on event input k (0 = bus error response, 1 = error, 2 = empty, 3 = timer) sets global status bit k+1 on the next clock edge. The bit stays set until it is cleared.
- R3: A clear write sets to zero, on the next edge, each global status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left unchanged.
- R4: If a clear write and a new event pulse hit the same status bit in the same cycle, the bit is left set.
- R5: A write to the enable register stores only bits 1 to 4. All other bits of global enable and global status read zero.
- R6: Bit 31 of the unmasked sources word is 1 exactly when some global status bit is set and is also enabled.
- R7: Bits 0 to NUM_PIPES-1 of the unmasked sources word follow the pipe request inputs in the same cycle. Bits NUM_PIPES to 30 read zero.
- R8: A mask write updates only the environment named by the select input, and only in bits 0 to NUM_PIPES-1 and bit 31. A select value of NUM_ENV or more changes no mask.
- R9: Each environment's masked sources word equals the unmasked word ANDed with that environment's mask. Its interrupt line, one cycle later, is the OR of that masked word.
- R10: An event sets its status bit even when the bit is not enabled. It raises bit 31 only once the bit is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_irq | input | NUM_PIPES | Interrupt request level, one bit per pipe |
| gevt_pulse | input | 4 | Global event pulses: bus error, error, empty, timer |
| en_wr | input | 1 | Write strobe for the global enable register |
| en_wdata | input | 32 | Write data for the global enable register |
| clr_wr | input | 1 | Write strobe for the global clear register |
| clr_wdata | input | 32 | Write-one-to-clear data |
| mask_wr | input | 1 | Write strobe for an environment mask |
| mask_sel | input | ENV_W | Environment selected by a mask write |
| mask_wdata | input | 32 | Mask write data |
| gstatus | output | 32 | Global status register |
| genable | output | 32 | Global enable register |
| src_unmasked | output | 32 | Sources word before masking |
| src_env | output | NUM_ENV*32 | Masked sources word, one per environment |
| mask_env | output | NUM_ENV*32 | Mask register, one per environment |
| irq_env | output | NUM_ENV | Interrupt line, one per environment |

## Verification
A status bit that is lost or stuck shows up on gstatus on the edge after the pulse or clear. It also changes bit 31 of the sources word in that same cycle whenever the bit is enabled. A mask that is corrupted or written into the wrong environment shows up at once on mask_env and src_env. The matching interrupt line diverges one cycle later. The reference model is compared against every output on every clock, so any divergence is reported within one or two cycles of its cause.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int WORD_W = 32;
  localparam int GBIT   = 31;
  localparam int NEVT   = 4;
  localparam logic [WORD_W-1:0] GSTAT_IMPL = 32'h0000_001E;

  function automatic logic [WORD_W-1:0] evt_to_word(input logic [NEVT-1:0] ev);
    return {{(WORD_W-NEVT-1){1'b0}}, ev, 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] src_impl(input int unsigned np);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < GBIT; i++) begin
      if (i < int'(np)) m[i] = 1'b1;
    end
    m[GBIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] build_src(input logic [WORD_W-1:0] pipes_ext,
                                                  input logic summary,
                                                  input logic [WORD_W-1:0] impl);
    logic [WORD_W-1:0] w;
    w = pipes_ext & impl;
    w[GBIT] = summary;
    return w;
  endfunction
endpackage

// File: rtl/irqagg_gstat.sv
module irqagg_gstat
  import irqagg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NEVT-1:0]       evt,
  input  logic                  en_wr,
  input  logic [WORD_W-1:0]     en_wdata,
  input  logic                  clr_wr,
  input  logic [WORD_W-1:0]     clr_wdata,
  output logic [WORD_W-1:0]     status,
  output logic [WORD_W-1:0]     enable,
  output logic                  summary
);
  logic [WORD_W-1:0] status_q, enable_q;
  logic [WORD_W-1:0] evt_set, clr_hit;

  assign evt_set = evt_to_word(evt);
  assign clr_hit = clr_wr ? (clr_wdata & GSTAT_IMPL) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= (status_q & ~clr_hit) | evt_set;
      if (en_wr) enable_q <= en_wdata & GSTAT_IMPL;
    end
  end

  assign status  = status_q;
  assign enable  = enable_q;
  assign summary = |(status_q & enable_q);

  for (genvar b = 1; b <= NEVT; b++) begin : g_bit
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[b-1] |=> status[b]);
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (status[b] && !(clr_wr && clr_wdata[b])) |=> status[b]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_wdata[b] && !evt[b-1]) |=> !status[b]);
    p_clear_vs_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_wdata[b] && evt[b-1]) |=> status[b]);
  end

  p_enable_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (enable == ($past(en_wdata) & GSTAT_IMPL)));
endmodule

// File: rtl/irqagg_srcword.sv
module irqagg_srcword
  import irqagg_pkg::*;
#(
  parameter int NUM_PIPES = 8
) (
  input  logic [NUM_PIPES-1:0] pipe_irq,
  input  logic                 summary,
  output logic [WORD_W-1:0]    src
);
  localparam logic [WORD_W-1:0] IMPL = src_impl(NUM_PIPES);
  logic [WORD_W-1:0] pipes_ext;

  always_comb begin
    pipes_ext = '0;
    pipes_ext[NUM_PIPES-1:0] = pipe_irq;
  end

  assign src = build_src(pipes_ext, summary, IMPL);
endmodule

// File: rtl/irqagg_env.sv
module irqagg_env
  import irqagg_pkg::*;
#(
  parameter int NUM_PIPES = 8,
  parameter int ENV_ID    = 0,
  parameter int ENV_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src_raw,
  input  logic              mask_wr,
  input  logic [ENV_W-1:0]  mask_sel,
  input  logic [WORD_W-1:0] mask_wdata,
  output logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] src_masked,
  output logic              irq
);
  localparam logic [WORD_W-1:0] IMPL = src_impl(NUM_PIPES);
  localparam logic [ENV_W-1:0]  MY_SEL = ENV_W'(ENV_ID);

  logic [WORD_W-1:0] mask_q;
  logic              irq_q;
  logic              sel_hit;

  assign sel_hit = mask_wr && (mask_sel == MY_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (sel_hit) mask_q <= mask_wdata & IMPL;
      irq_q <= |(src_raw & mask_q);
    end
  end

  assign mask       = mask_q;
  assign src_masked = src_raw & mask_q;
  assign irq        = irq_q;

  p_mask_isolated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_wr || mask_sel != MY_SEL) |=> $stable(mask));
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(src_raw & mask))));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int NUM_PIPES = 8,
  parameter int NUM_ENV   = 4,
  parameter int ENV_W     = (NUM_ENV > 1) ? $clog2(NUM_ENV) + 1 : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_PIPES-1:0]      pipe_irq,
  input  logic [3:0]                gevt_pulse,
  input  logic                      en_wr,
  input  logic [31:0]               en_wdata,
  input  logic                      clr_wr,
  input  logic [31:0]               clr_wdata,
  input  logic                      mask_wr,
  input  logic [ENV_W-1:0]          mask_sel,
  input  logic [31:0]               mask_wdata,
  output logic [31:0]               gstatus,
  output logic [31:0]               genable,
  output logic [31:0]               src_unmasked,
  output logic [NUM_ENV*32-1:0]     src_env,
  output logic [NUM_ENV*32-1:0]     mask_env,
  output logic [NUM_ENV-1:0]        irq_env
);
  localparam logic [WORD_W-1:0] IMPL = src_impl(NUM_PIPES);
  logic summary;

  irqagg_gstat u_gstat (
    .clk(clk), .rst_n(rst_n), .evt(gevt_pulse),
    .en_wr(en_wr), .en_wdata(en_wdata),
    .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .status(gstatus), .enable(genable), .summary(summary)
  );

  irqagg_srcword #(.NUM_PIPES(NUM_PIPES)) u_src (
    .pipe_irq(pipe_irq), .summary(summary), .src(src_unmasked)
  );

  for (genvar e = 0; e < NUM_ENV; e++) begin : g_env
    irqagg_env #(.NUM_PIPES(NUM_PIPES), .ENV_ID(e), .ENV_W(ENV_W)) u_env (
      .clk(clk), .rst_n(rst_n), .src_raw(src_unmasked),
      .mask_wr(mask_wr), .mask_sel(mask_sel), .mask_wdata(mask_wdata),
      .mask(mask_env[e*32 +: 32]), .src_masked(src_env[e*32 +: 32]),
      .irq(irq_env[e])
    );
  end

  p_summary_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_unmasked[GBIT] == |(gstatus & genable));
  p_pipe_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (src_unmasked[NUM_PIPES-1:0] == pipe_irq) && ((src_unmasked & ~IMPL) == '0));
  p_status_impl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((gstatus | genable) & ~GSTAT_IMPL) == '0);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_env == '0));
endmodule

// File: tb/tb_irqagg_top.sv
`timescale 1ns/1ps
module tb_irqagg_top;
  localparam int NP = 8;
  localparam int NE = 4;
  localparam int EW = 3;
  localparam logic [31:0] SRC_OK = 32'h8000_00FF;
  localparam logic [31:0] GS_OK  = 32'h0000_001E;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pipe_irq = '0;
  logic [3:0] gevt_pulse = '0;
  logic en_wr = 0, clr_wr = 0, mask_wr = 0;
  logic [31:0] en_wdata = '0, clr_wdata = '0, mask_wdata = '0;
  logic [EW-1:0] mask_sel = '0;
  logic [31:0] gstatus, genable, src_unmasked;
  logic [NE*32-1:0] src_env, mask_env;
  logic [NE-1:0] irq_env;

  irqagg_top #(.NUM_PIPES(NP), .NUM_ENV(NE)) dut (
    .clk(clk), .rst_n(rst_n), .pipe_irq(pipe_irq), .gevt_pulse(gevt_pulse),
    .en_wr(en_wr), .en_wdata(en_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .mask_wr(mask_wr), .mask_sel(mask_sel), .mask_wdata(mask_wdata),
    .gstatus(gstatus), .genable(genable), .src_unmasked(src_unmasked),
    .src_env(src_env), .mask_env(mask_env), .irq_env(irq_env)
  );

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [31:0] m_stat, m_en;
  logic [31:0] m_mask [NE];
  logic [NE-1:0] m_irq;

  function automatic logic [31:0] m_raw();
    logic [31:0] w;
    w = {24'b0, pipe_irq};
    if ((m_stat & m_en) != 0) w = w | 32'h8000_0000;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= '0; m_en <= '0; m_irq <= '0;
      for (int e = 0; e < NE; e++) m_mask[e] <= '0;
    end else begin
      logic [31:0] raw, clr;
      raw = m_raw();
      for (int e = 0; e < NE; e++) m_irq[e] <= ((raw & m_mask[e]) != 0);
      clr = clr_wr ? (clr_wdata & GS_OK) : 32'h0;
      m_stat <= (m_stat & ~clr) | ({28'b0, gevt_pulse} << 1);
      if (en_wr) m_en <= en_wdata & GS_OK;
      if (mask_wr && int'(mask_sel) < NE) m_mask[mask_sel] <= mask_wdata & SRC_OK;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 status", gstatus, m_stat);
      chk("R5 enable", genable, m_en);
      chk("R7 unmasked", src_unmasked, m_raw());
      for (int e = 0; e < NE; e++) begin
        chk("R8 mask", mask_env[e*32 +: 32], m_mask[e]);
        chk("R9 masked src", src_env[e*32 +: 32], m_raw() & m_mask[e]);
      end
      chk("R9 irq", {28'b0, irq_env}, {28'b0, m_irq});
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    gevt_pulse = '0; en_wr = 0; clr_wr = 0; mask_wr = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R1 reset state
    chk("R1 status", gstatus, 0);
    chk("R1 enable", genable, 0);
    chk("R1 masks", mask_env[31:0] | mask_env[63:32] | mask_env[95:64] | mask_env[127:96], 0);
    chk("R1 irq", {28'b0, irq_env}, 0);

    // R2 / R10: events set status while not enabled
    gevt_pulse = 4'b0100; cyc(); idle();
    chk("R2 empty sets bit3", gstatus, 32'h8);
    chk("R10 not enabled, bit31 low", {31'b0, src_unmasked[31]}, 0);
    gevt_pulse = 4'b1001; cyc(); idle(); cyc();
    chk("R2 sticky", gstatus, 32'h1A);

    // R5 enable write all ones
    en_wr = 1; en_wdata = 32'hFFFF_FFFF; cyc(); idle();
    chk("R5 enable impl bits", genable, 32'h1E);
    chk("R6 summary high", {31'b0, src_unmasked[31]}, 1);
    en_wr = 1; en_wdata = 32'h0000_0006; cyc(); idle();
    chk("R6 summary via error/buserr", {31'b0, src_unmasked[31]}, 1);

    // R3 partial clear
    clr_wr = 1; clr_wdata = 32'h0000_0002; cyc(); idle();
    chk("R3 partial clear", gstatus, 32'h18);
    chk("R6 summary low after clear", {31'b0, src_unmasked[31]}, 0);

    // R4 clear and set together
    clr_wr = 1; clr_wdata = 32'hFFFF_FFFF; gevt_pulse = 4'b0010; cyc(); idle();
    chk("R4 clear vs set", gstatus, 32'h4);

    // R8 masks
    mask_wr = 1; mask_sel = 3'd0; mask_wdata = 32'hFFFF_FFFF; cyc(); idle();
    chk("R8 env0 mask", mask_env[31:0], SRC_OK);
    chk("R8 env1 untouched", mask_env[63:32], 0);
    mask_wr = 1; mask_sel = 3'd2; mask_wdata = 32'h0000_0030; cyc(); idle();
    mask_wr = 1; mask_sel = 3'd5; mask_wdata = 32'hFFFF_FFFF; cyc(); idle();
    chk("R8 out of range select", mask_env[127:96], 0);
    chk("R8 env2 mask", mask_env[95:64], 32'h30);

    // R7 / R9 pipe patterns
    pipe_irq = 8'h10; cyc();
    chk("R7 pipe bits", src_unmasked, 32'h8000_0010);
    chk("R9 env2 masked", src_env[95:64], 32'h10);
    cyc();
    chk("R9 env2 irq", {31'b0, irq_env[2]}, 1);
    chk("R9 env3 irq", {31'b0, irq_env[3]}, 0);
    pipe_irq = 8'h00; clr_wr = 1; clr_wdata = 32'h4; cyc(); idle(); cyc();
    chk("R9 env0 irq drops", {31'b0, irq_env[0]}, 0);

    // mixed random traffic checked by the model
    for (int i = 0; i < 2000; i++) begin
      pipe_irq   = NP'($urandom);
      gevt_pulse = (($urandom % 4) == 0) ? 4'($urandom) : 4'b0;
      en_wr      = (($urandom % 16) == 0); en_wdata = $urandom;
      clr_wr     = (($urandom % 5) == 0);  clr_wdata = $urandom;
      mask_wr    = (($urandom % 8) == 0);  mask_sel = EW'($urandom); mask_wdata = $urandom;
      cyc();
    end
    idle(); cyc();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule